// File: doc/BRIEF.md
# Floating-Point Predicate Compare Unit

This unit takes two IEEE-754 operands, both single or both double precision as a precision input selects, and reduces their relation to one of four outcomes: less, equal, greater or unordered. A 3-bit condition code then picks one of eight predicates over that relation. The unit returns a single condition flag and the status word to write back. The caller holds that status word in its own register.

The status word written back carries the flag in bit 29 and clears bits 31, 30 and 28. Bits 27:0 of the old word come back unchanged. The compare is quiet: a quiet NaN only makes the relation unordered, while a signaling NaN also raises an invalid-operation output. A request is accepted whenever `in_valid` is high. Its results appear one clock later, together with `out_done`, and they hold until the next request.

Top module: `fp_pred_cmp`

## Requirements
- R1: Every cycle in which `in_valid` is high gives `out_done` high exactly one clock later. `out_done` is low after any cycle without a request, and `flag_out`, `invalid_out` and `stat_out` keep their values.
- R2: Write lt, eq and un for the outcomes "less", "equal" and "unordered". The flag is 0 for code 0, un for 1, eq for 2, un|eq for 3, lt for 4, lt|un for 5, lt|eq for 6, and, for code 7, true unless a is greater than b.
- R3: The flag is recomputed from scratch on every request. A flag that is true from the previous request has no effect on the next one.
- R4: `stat_out` is built as follows: bit 29 equals `flag_out`, bits 31, 30 and 28 are 0, and bits 27:0 equal `stat_keep` of the request.
- R5: When `is_dbl`=0, an operand is bits 31:0 (sign 31, exponent 30:23, fraction 22:0), and bits 63:32 are ignored. When `is_dbl`=1, it is bits 63:0 (sign 63, exponent 62:52, fraction 51:0). An all-ones exponent with a nonzero fraction is a NaN, and either operand being a NaN makes the relation unordered.
- R6: Positive zero and negative zero compare equal in both precisions.
- R7: Non-NaN operands order by sign and magnitude. Any negative value is below any positive value, and among negatives a larger magnitude is smaller. Infinities sit at the ends.
- R8: `invalid_out` is 1 exactly when an operand is a signaling NaN, that is a NaN whose top fraction bit (22 single, 51 double) is 0. Quiet NaNs leave it at 0.
- R9: After reset, `out_done`, `flag_out`, `invalid_out` and `stat_out` are all 0.
- R10: The same predicate table applies to double precision operands as to single.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| is_dbl | input | 1 | 1 = double precision, 0 = single in bits 31:0 |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| cond_sel | input | 3 | Predicate code |
| stat_keep | input | 28 | Bits 27:0 of the old status word |
| out_done | output | 1 | Result valid, one cycle after request |
| flag_out | output | 1 | Predicate result |
| invalid_out | output | 1 | Signaling NaN seen |
| stat_out | output | 32 | Status word to write back |

## Verification
Every result is due one clock after the request: `out_done`, `flag_out`, `invalid_out` and `stat_out` all come from one register stage. The bench drives a request on a falling edge and samples all four outputs on the next falling edge, which is after the single capturing rising edge. It then drops `in_valid` for one cycle and samples again one falling edge later, confirming that `out_done` falls and the flag holds. Expected relations come from an order-preserving integer key computed in the bench. Operands are swept over all pairs of a fixed set of special and ordinary values, with every code, in both precisions.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int OP_W    = 64;
  localparam int SGL_EXP = 8;
  localparam int SGL_MAN = 23;
  localparam int DBL_EXP = 11;
  localparam int DBL_MAN = 52;
  localparam int MAG_W   = OP_W - 1;

  typedef enum logic [1:0] {REL_LT, REL_EQ, REL_GT, REL_UN} rel_e;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             snan;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } opnd_info_t;

  function automatic opnd_info_t classify_op(input logic [OP_W-1:0] raw, input logic dbl);
    opnd_info_t r;
    logic exp_ones, man_nz, quiet;
    if (dbl) begin
      r.sign   = raw[OP_W-1];
      exp_ones = &raw[DBL_MAN +: DBL_EXP];
      man_nz   = |raw[DBL_MAN-1:0];
      quiet    = raw[DBL_MAN-1];
      r.mag    = raw[MAG_W-1:0];
    end else begin
      r.sign   = raw[SGL_EXP+SGL_MAN];
      exp_ones = &raw[SGL_MAN +: SGL_EXP];
      man_nz   = |raw[SGL_MAN-1:0];
      quiet    = raw[SGL_MAN-1];
      r.mag    = {{(MAG_W-SGL_EXP-SGL_MAN){1'b0}}, raw[SGL_EXP+SGL_MAN-1:0]};
    end
    r.nan  = exp_ones & man_nz;
    r.snan = r.nan & ~quiet;
    r.zero = (r.mag == '0);
    return r;
  endfunction

  function automatic rel_e relate_ops(input opnd_info_t a, input opnd_info_t b);
    if (a.nan || b.nan)                        return REL_UN;
    if (a.zero && b.zero)                      return REL_EQ;
    if (a.sign != b.sign)                      return a.sign ? REL_LT : REL_GT;
    if (a.mag == b.mag)                        return REL_EQ;
    if ((a.mag < b.mag) ^ a.sign)              return REL_LT;
    return REL_GT;
  endfunction

  // code bit 0 admits unordered, bit 1 equal, bit 2 less
  function automatic logic pred_hit(input rel_e rel, input logic [2:0] code);
    return (code[0] && rel == REL_UN) || (code[1] && rel == REL_EQ) ||
           (code[2] && rel == REL_LT);
  endfunction
endpackage

// File: rtl/fpc_classify.sv
module fpc_classify
  import fpc_pkg::*;
(
  input  logic [OP_W-1:0] raw,
  input  logic            dbl,
  output opnd_info_t      info
);
  always_comb info = classify_op(raw, dbl);
endmodule

// File: rtl/fpc_relate.sv
module fpc_relate
  import fpc_pkg::*;
(
  input  opnd_info_t a_info,
  input  opnd_info_t b_info,
  output rel_e       rel,
  output logic       unord
);
  always_comb begin
    rel   = relate_ops(a_info, b_info);
    unord = a_info.nan | b_info.nan;
  end
endmodule

// File: rtl/fpc_predicate.sv
module fpc_predicate
  import fpc_pkg::*;
(
  input  rel_e       rel,
  input  logic [2:0] code,
  output logic       hit
);
  always_comb hit = pred_hit(rel, code);
endmodule

// File: rtl/fp_pred_cmp.sv
module fp_pred_cmp
  import fpc_pkg::*;
#(
  parameter int STAT_W   = 32,
  parameter int KEEP_W   = 28,
  parameter int FLAG_POS = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              is_dbl,
  input  logic [OP_W-1:0]   opnd_a,
  input  logic [OP_W-1:0]   opnd_b,
  input  logic [2:0]        cond_sel,
  input  logic [KEEP_W-1:0] stat_keep,
  output logic              out_done,
  output logic              flag_out,
  output logic              invalid_out,
  output logic [STAT_W-1:0] stat_out
);
  localparam int HI_W = STAT_W - KEEP_W;

  opnd_info_t info [2];
  logic [OP_W-1:0] raw [2];
  assign raw[0] = opnd_a;
  assign raw[1] = opnd_b;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fpc_classify u_cls (.raw(raw[g]), .dbl(is_dbl), .info(info[g]));
  end

  rel_e rel;
  logic unord, hit, snan_seen;
  logic [HI_W-1:0] hi_bits;

  fpc_relate    u_rel  (.a_info(info[0]), .b_info(info[1]), .rel(rel), .unord(unord));
  fpc_predicate u_pred (.rel(rel), .code(cond_sel), .hit(hit));

  assign snan_seen = info[0].snan | info[1].snan;

  always_comb begin
    hi_bits = '0;
    hi_bits[FLAG_POS-KEEP_W] = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_done    <= 1'b0;
      flag_out    <= 1'b0;
      invalid_out <= 1'b0;
      stat_out    <= '0;
    end else begin
      out_done <= in_valid;
      if (in_valid) begin
        flag_out    <= hit;
        invalid_out <= snan_seen;
        stat_out    <= {hi_bits, stat_keep};
      end
    end
  end

  p_done_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done);
  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_done && $stable(flag_out) && $stable(stat_out)));
  p_code0_false_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_sel == 3'd0) |=> !flag_out);
  p_code7_gt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cond_sel == 3'd7) |=> (flag_out == ($past(rel) != REL_GT)));
  p_flag_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (stat_out[FLAG_POS] == flag_out && stat_out[STAT_W-1 -: 2] == 2'b00
                  && stat_out[KEEP_W] == 1'b0));
  p_keep_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> stat_out[KEEP_W-1:0] == $past(stat_keep));
  p_nan_unord_r5: assert property (@(posedge clk) disable iff (!rst_n)
    unord |-> rel == REL_UN);
  p_invalid_unord_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !unord) |=> !invalid_out);
endmodule

// File: tb/fp_pred_cmp_tb_top.sv
`timescale 1ns/1ps
module fp_pred_cmp_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, is_dbl = 1'b0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic [2:0]  cond_sel = '0;
  logic [27:0] stat_keep = '0;
  logic out_done, flag_out, invalid_out;
  logic [31:0] stat_out;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  fp_pred_cmp dut_i (.clk, .rst_n, .in_valid, .is_dbl, .opnd_a, .opnd_b, .cond_sel,
    .stat_keep, .out_done, .flag_out, .invalid_out, .stat_out);

  function automatic logic [63:0] sgl_pat(input int i);
    case (i)
      0: return 64'h0000_0000; 1: return 64'h8000_0000; 2: return 64'h3F80_0000;
      3: return 64'h4000_0000; 4: return 64'hBF80_0000; 5: return 64'hC000_0000;
      6: return 64'h7F80_0000; 7: return 64'hFF80_0000; 8: return 64'h7FC0_0000;
      9: return 64'h7F80_0001; 10: return 64'h0000_0001; 11: return 64'h7F7F_FFFF;
      default: return 64'hFFA0_0000;
    endcase
  endfunction

  function automatic logic [63:0] dbl_pat(input int i);
    case (i)
      0: return 64'h0; 1: return 64'h8000_0000_0000_0000; 2: return 64'h3FF0_0000_0000_0000;
      3: return 64'h4000_0000_0000_0000; 4: return 64'hBFF0_0000_0000_0000;
      5: return 64'hC000_0000_0000_0000; 6: return 64'h7FF0_0000_0000_0000;
      7: return 64'hFFF0_0000_0000_0000; 8: return 64'h7FF8_0000_0000_0000;
      9: return 64'h7FF0_0000_0000_0001; 10: return 64'h1;
      11: return 64'h7FEF_FFFF_FFFF_FFFF;
      default: return 64'hFFF4_0000_0000_0000;
    endcase
  endfunction

  // value aligned to the top of 64 bits
  function automatic logic [63:0] top_al(input logic [63:0] v, input logic d);
    return d ? v : {v[31:0], 32'h0};
  endfunction
  function automatic logic is_nan(input logic [63:0] v, input logic d);
    logic [63:0] t = top_al(v, d) & 64'h7FFF_FFFF_FFFF_FFFF;
    return d ? (t > 64'h7FF0_0000_0000_0000) : (t > 64'h7F80_0000_0000_0000);
  endfunction
  function automatic logic is_snan(input logic [63:0] v, input logic d);
    return is_nan(v, d) && (d ? !v[51] : !v[22]);
  endfunction
  function automatic logic [63:0] okey(input logic [63:0] v, input logic d);
    logic [63:0] t = top_al(v, d);
    if ((t << 1) == 64'h0) return 64'h8000_0000_0000_0000;
    return t[63] ? ~t : (t | 64'h8000_0000_0000_0000);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic d, input logic [63:0] a, input logic [63:0] b,
                        input logic [2:0] c, input logic [27:0] k);
    logic un, eq, lt, gt, ef, einv;
    logic [31:0] es;
    string tag;
    un = is_nan(a, d) || is_nan(b, d);
    eq = !un && okey(a, d) == okey(b, d);
    lt = !un && okey(a, d) < okey(b, d);
    gt = !un && !eq && !lt;
    case (c)  // R2 table
      3'd0: ef = 1'b0;    3'd1: ef = un;       3'd2: ef = eq;       3'd3: ef = un | eq;
      3'd4: ef = lt;      3'd5: ef = lt | un;  3'd6: ef = lt | eq;  default: ef = !gt;
    endcase
    einv = is_snan(a, d) || is_snan(b, d);
    es = {2'b00, ef, 1'b0, k};
    if (un) tag = "R5";
    else if (okey(a, d) == 64'h8000_0000_0000_0000 && eq) tag = "R6";
    else if (d) tag = "R10";
    else if (top_al(a, d)[63] || top_al(b, d)[63]) tag = "R7";
    else tag = "R2";
    @(negedge clk);
    is_dbl = d; opnd_a = a; opnd_b = b; cond_sel = c; stat_keep = k; in_valid = 1'b1;
    @(negedge clk);
    chk(out_done == 1'b1, "R1 done", 64'(out_done), 64'd1);
    chk(flag_out == ef, tag, 64'(flag_out), 64'(ef));
    chk(stat_out == es, "R4 status", 64'(stat_out), 64'(es));
    chk(invalid_out == einv, "R8 invalid", 64'(invalid_out), 64'(einv));
    in_valid = 1'b0;
    opnd_a = ~opnd_a; opnd_b = 64'h0; cond_sel = ~cond_sel;
    @(negedge clk);
    chk(out_done == 1'b0, "R1 idle done", 64'(out_done), 64'd0);
    chk(flag_out == ef && stat_out == es, "R1 hold", 64'(stat_out), 64'(es));
  endtask

  initial begin
    #15_000_000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12;
    chk(out_done == 0 && flag_out == 0 && invalid_out == 0 && stat_out == 0,
        "R9 reset", {32'(out_done), stat_out}, 64'd0);
    rst_n = 1'b1;
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 13; i++)
        for (int j = 0; j < 13; j++)
          for (int c = 0; c < 8; c++) begin
            logic [63:0] a, b;
            // single mode: junk in bits 63:32 must be ignored (R5)
            a = d ? dbl_pat(i) : (sgl_pat(i) | {32'hA5A5_0000 + 32'(i), 32'h0});
            b = d ? dbl_pat(j) : (sgl_pat(j) | {32'h5A5A_0000 + 32'(j), 32'h0});
            run_op(d[0], a, b, c[2:0], 28'(32'h9E37_79B9 * (i * 104 + j * 8 + c + 1)));
          end
    // R3: a true result followed by a false one under code 0
    run_op(1'b0, 64'h3F80_0000, 64'h3F80_0000, 3'd7, 28'hFFF_FFFF);
    run_op(1'b0, 64'h3F80_0000, 64'h3F80_0000, 3'd0, 28'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule